// File: doc/BRIEF.md
# Framed Serial PCM Sample Port

This block moves 14-bit linear voice samples between a converter datapath and an external frame-synchronous serial link. The link supplies a bit clock and a frame strobe. Once per frame the block sends one transmit sample out serially and collects one receive sample. The nominal rates are a 2.048 MHz bit clock and an 8 kHz strobe, which gives 256 bit periods per frame. Toward the converter side there are two parallel words. One is a transmit word that the block takes in at each frame start. The other is a receive word that comes with a one-period valid pulse.

Inputs from the link are sampled on the falling edge of the bit clock. The serial output is launched on the rising edge. A frame begins when the frame strobe is first seen high on a falling edge. The sample then occupies the next 14 bit slots, MSB first, and the line stays low for the rest of the frame. A control input routes the outgoing stream back into the receiver in place of the serial input, which allows a self-test without external wiring. If a strobe arrives early, the block drops the frame in progress and aligns to the new strobe.

Top module: `pcm_serial_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sout` goes to 0, `rx_word` goes to 0 and `rx_valid` goes to 0.
- R2: A frame starts when `fs` is sampled high on a falling edge after having been sampled low on the previous falling edge. If `fs` stays high across several falling edges, only one frame starts.
- R3: On the first rising edge after a frame start, `sout` carries bit 13 of `tx_word`. Bits 12 down to 0 follow on the next 13 rising edges, one per edge.
- R4: The transmit word is captured at the frame start. Changes on `tx_word` during the frame do not alter the bits sent.
- R5: Outside the 14 sample slots, and when no frame has started, `sout` is 0.
- R6: The receive bit for slot k is sampled on the falling edge that follows the launch of slot k, MSB first. On the falling edge that captures slot 13, `rx_word` takes the assembled 14 bits and `rx_valid` goes high for exactly one bit period.
- R7: `rx_word` holds its value between captures.
- R8: When `loop_en` is 1, the receiver takes its bits from `sout` and ignores `sin`, so the received word equals the transmitted word.
- R9: An `fs` rising edge that arrives before the frame ends restarts the slot count at 0 and reloads the transmit word.
- R10: Without a new frame start, the slot count stops at its last value. No further bits are sent and no further words are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| fs | input | 1 | Frame strobe, sampled on the falling edge |
| sin | input | 1 | Serial receive data, sampled on the falling edge |
| loop_en | input | 1 | 1 routes `sout` into the receiver instead of `sin` |
| tx_word | input | 14 | Two's-complement transmit sample, captured at frame start |
| sout | output | 1 | Serial transmit data, launched on the rising edge |
| rx_word | output | 14 | Last assembled receive sample |
| rx_valid | output | 1 | One-period pulse when `rx_word` is updated |

## Verification
Several properties are checked on every cycle by the embedded assertions. These are: the slot counter restarting at a frame start and otherwise counting up to its stop value, the line staying quiet outside the sample slots, the valid pulse lasting a single period, and the receive word holding between pulses. Other behaviours can only be shown by the bench's directed scenarios, because they need knowledge of the intended data. These are the bit order on both wires, capture of the transmit word at the frame start, the loopback path ignoring `sin`, realignment on an early strobe, and a long strobe starting a single frame.

// File: rtl/pcm_pkg.sv
// Package: shared sizing for the framed serial PCM port.
// Assumes: one sample per direction per frame, sample width at least 3.
package pcm_pkg;
    parameter int unsigned PCM_SAMPLE_W   = 14;
    parameter int unsigned PCM_FRAME_BITS = 256;
endpackage

// File: rtl/pcm_frame_timer.sv
// Module: frame timer.
// Samples the frame strobe on the falling edge and detects its rising
// transition. Keeps the bit-slot counter, which advances on the rising edge.
// Assumes: FRAME_BITS is at least SAMPLE_W + 2; the counter stops at its last
// value until the next strobe.
module pcm_frame_timer #(
    parameter int unsigned SAMPLE_W   = 14,
    parameter int unsigned FRAME_BITS = 256,
    localparam int unsigned SLOT_W    = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_start
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

    logic fs_now;
    logic fs_prev;

    // Purpose: sample the strobe on the falling edge and keep the previous sample.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fs_now  <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            fs_now  <= fs;
            fs_prev <= fs_now;
        end
    end

    assign frame_start = fs_now & ~fs_prev;

    // Purpose: restart the slot count on a frame start, else count up to the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= LAST_SLOT;
        end else if (frame_start) begin
            slot <= '0;
        end else if (slot != LAST_SLOT) begin
            slot <= slot + 1'b1;
        end
    end

    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> slot == '0); // R9
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && slot != LAST_SLOT) |=> slot == $past(slot) + 1'b1); // R10
    AST_SLOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && slot == LAST_SLOT) |=> slot == LAST_SLOT); // R10
endmodule

// File: rtl/pcm_tx_shifter.sv
// Module: transmit shifter.
// Takes in the parallel word on a frame start and launches it MSB first on
// rising edges. Zeros shift in behind the data, so the line stays low after
// the last bit.
// Assumes: load is stable across the rising edge (it comes from falling-edge flops).
module pcm_tx_shifter #(
    parameter int unsigned SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] tx_word,
    output logic                sout
);
    logic [SAMPLE_W-2:0] rest;

    // Purpose: load the word and launch its MSB, or shift the remaining bits out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sout <= 1'b0;
            rest <= '0;
        end else if (load) begin
            sout <= tx_word[SAMPLE_W-1];
            rest <= tx_word[SAMPLE_W-2:0];
        end else begin
            sout <= rest[SAMPLE_W-2];
            rest <= {rest[SAMPLE_W-3:0], 1'b0};
        end
    end

    AST_TX_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sout == $past(tx_word[SAMPLE_W-1])); // R3
endmodule

// File: rtl/pcm_rx_shifter.sv
// Module: receive shifter.
// Samples one bit per sample slot on the falling edge, MSB first. After the
// last slot it publishes the word with a one-period valid pulse.
// Assumes: slot comes from rising-edge flops and is stable at the falling edge.
module pcm_rx_shifter #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned SLOT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                bit_in,
    output logic [SAMPLE_W-1:0] rx_word,
    output logic                rx_valid
);
    localparam logic [SLOT_W-1:0] FINAL_SLOT = SLOT_W'(SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] acc;
    logic                in_window;

    assign in_window = (slot <= FINAL_SLOT);

    // Purpose: shift in sample bits and publish the word after the final slot.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (in_window) begin
                acc <= {acc[SAMPLE_W-2:0], bit_in};
            end
            if (slot == FINAL_SLOT) begin
                rx_word  <= {acc[SAMPLE_W-2:0], bit_in};
                rx_valid <= 1'b1;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_WORD_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word)); // R7
endmodule

// File: rtl/pcm_serial_port.sv
// Module: framed serial PCM sample port (top).
// Connects the frame timer, the transmit shifter and the receive shifter, and
// selects the receive source: the serial input, or the outgoing stream in loopback.
// Assumes: clk is the serial bit clock; fs and sin meet setup and hold around
// its falling edge.
module pcm_serial_port
    import pcm_pkg::*;
#(
    parameter int unsigned SAMPLE_W   = PCM_SAMPLE_W,
    parameter int unsigned FRAME_BITS = PCM_FRAME_BITS,
    localparam int unsigned SLOT_W    = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fs,
    input  logic                sin,
    input  logic                loop_en,
    input  logic [SAMPLE_W-1:0] tx_word,
    output logic                sout,
    output logic [SAMPLE_W-1:0] rx_word,
    output logic                rx_valid
);
    logic [SLOT_W-1:0] slot;
    logic              frame_start;
    logic              rx_bit;

    pcm_frame_timer #(
        .SAMPLE_W   (SAMPLE_W),
        .FRAME_BITS (FRAME_BITS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs          (fs),
        .slot        (slot),
        .frame_start (frame_start)
    );

    pcm_tx_shifter #(
        .SAMPLE_W (SAMPLE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_start),
        .tx_word (tx_word),
        .sout    (sout)
    );

    // Purpose: pick the receive bit source.
    always_comb begin
        rx_bit = loop_en ? sout : sin;
    end

    pcm_rx_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .bit_in   (rx_bit),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    AST_SOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot >= SLOT_W'(SAMPLE_W)) |-> !sout); // R5
    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (!sout && rx_word == '0 && !rx_valid)); // R1
endmodule

// File: tb/pcm_serial_port_test.sv
// Directed bench for the framed serial PCM port. Inputs are driven and
// outputs sampled 1 ns after each rising edge.
module pcm_serial_port_test;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fs = 1'b0;
    logic         sin = 1'b0;
    logic         loop_en = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         sout;
    logic [W-1:0] rx_word;
    logic         rx_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pcm_serial_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs       (fs),
        .sin      (sin),
        .loop_en  (loop_en),
        .tx_word  (tx_word),
        .sout     (sout),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Raise the strobe (after one slot period) and present the word to send.
    task automatic start_frame(input logic [W-1:0] tx);
        tick();
        fs = 1'b1;
        tx_word = tx;
    endtask

    // Run nbits slots after a strobe. Keeps fs high for `hold` slots, corrupts
    // tx_word after capture, checks sout and drives sin.
    task automatic frame_bits(input logic [W-1:0] tx, input logic [W-1:0] rx,
                              input int nbits, input int hold, input string req);
        for (int k = 0; k < nbits; k++) begin
            tick();
            if (k >= hold) fs = 1'b0;
            check(req, 32'(sout), 32'(tx[W-1-k]));
            sin = rx[W-1-k];
            tx_word = ~tx; // R4: later changes must not reach the line
        end
    endtask

    // Expect the captured word and a single-period valid pulse.
    task automatic finish_frame(input logic [W-1:0] exp, input string req);
        tick();
        fs = 1'b0;
        check({req, " valid"}, 32'(rx_valid), 32'd1);
        check({req, " word"}, 32'(rx_word), 32'(exp));
        check("R5 quiet after data", 32'(sout), 32'd0);
        tick();
        check("R6 pulse width", 32'(rx_valid), 32'd0);
        check("R7 word held", 32'(rx_word), 32'(exp));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) tick();
        check("R1 sout", 32'(sout), 32'd0);
        check("R1 rx_word", 32'(rx_word), 32'd0);
        check("R1 rx_valid", 32'(rx_valid), 32'd0);
        rst_n = 1'b1;
        repeat (3) tick();
        check("R5 idle before first frame", 32'(sout), 32'd0);
    endtask

    task automatic test_basic(input logic [W-1:0] tx, input logic [W-1:0] rx);
        start_frame(tx);
        frame_bits(tx, rx, W, 1, "R3 R4 bit order");
        finish_frame(rx, "R6 capture");
    endtask

    task automatic test_long_strobe();
        start_frame(14'h2A5C);
        frame_bits(14'h2A5C, 14'h1337, W, 4, "R2 long strobe");
        finish_frame(14'h1337, "R2 R6 single frame");
    endtask

    task automatic test_loopback();
        loop_en = 1'b1;
        start_frame(14'h0F3C);
        frame_bits(14'h0F3C, 14'h3FFF, W, 1, "R8 loop tx");
        finish_frame(14'h0F3C, "R8 loop capture");
        loop_en = 1'b0;
    endtask

    task automatic test_realign();
        start_frame(14'h3333);
        frame_bits(14'h3333, 14'h0AAA, 5, 1, "R9 first frame part");
        start_frame(14'h1C71);
        frame_bits(14'h1C71, 14'h2468, W, 1, "R9 realigned tx");
        finish_frame(14'h2468, "R9 realigned rx");
    endtask

    task automatic test_idle();
        int bad_out = 0;
        int bad_valid = 0;
        for (int k = 0; k < 300; k++) begin
            tick();
            sin = k[0];
            if (sout !== 1'b0) bad_out++;
            if (rx_valid !== 1'b0) bad_valid++;
        end
        check("R10 no bits after frame end", 32'(bad_out), 32'd0);
        check("R10 no capture after frame end", 32'(bad_valid), 32'd0);
        check("R7 word kept over idle", 32'(rx_word), 32'h2468);
    endtask

    initial begin
        test_reset();
        test_basic(14'h2001, 14'h1FFE);
        test_basic(14'h3FFF, 14'h0000);
        test_basic(14'h0000, 14'h2ABC);
        test_long_strobe();
        test_loopback();
        test_realign();
        test_idle();
        test_basic(14'h1234, 14'h0421);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule